// File: doc/BRIEF.md
# Sparse ADC Event Formatter

This block packs one snapshot of a multi-channel converter into a compact, zero-suppressed packet of 16-bit words. A snapshot has a 12-bit result for each channel and a mask that shows which channels hold a valid result. The block emits the packet on a valid/ready stream. Channels without a valid result cost no output word.

A packet always has the same frame. It opens with a configurable tag word. A pattern word follows, with one bit per channel. Then comes one word for each channel that fired, in ascending channel order. Each of these words carries the channel index in its upper four bits and the converted value in its lower twelve. The packet closes with an end marker, which is the tag with its upper nibble set to all ones. A downstream parser can find its way through a mixed stream using only the tag and the pattern word.

The block takes one snapshot at a time. It does not offer a new capture until the end marker of the current packet has been accepted downstream.

Top module: `sparse_adc_packer`

## Requirements
- R1: The first word of every packet equals the parameter TAG.
- R2: The second word is the hit pattern. Bit i is 1 exactly when channel i was marked valid at capture, and bits at or above CHANNELS are 0.
- R3: A data word appears only for a channel whose pattern bit is set, and every set bit yields exactly one data word.
- R4: In a data word, bits 15:12 hold the channel index and bits 11:0 hold that channel's 12-bit value as captured.
- R5: Data words come out in strictly ascending channel order.
- R6: The last word of a packet is {4'hF, TAG[11:0]}. In the cycle after it is accepted, out_valid is low and cap_ready is high.
- R7: A capture with an all-zero mask gives a three-word packet: tag, zero pattern word, end marker.
- R8: cap_ready is high only while no packet is in flight. A capture offered while a packet is in flight is ignored and does not change that packet.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_word holds its value.
- R10: After reset, out_valid is low and cap_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_valid | input | 1 | Snapshot offered |
| cap_ready | output | 1 | Block idle; snapshot taken when cap_valid is also high |
| cap_mask | input | CHANNELS | Per-channel valid flags, bit i for channel i |
| cap_vals | input | CHANNELS*12 | Channel values, channel i at bits 12*i+11 : 12*i |
| out_valid | output | 1 | out_word holds a packet word |
| out_ready | input | 1 | Downstream accepts out_word |
| out_word | output | 16 | Packet word |

## Verification
The bench builds the block with the full 16 channels and a tag of 0x7166. At this setting the channel index uses the whole upper nibble, so channel 15 with a value of 0x166 produces a data word equal to the end marker. The sequencer must therefore decide framing from its state and never from word values. The tests cover masks with only channel 0 or only channel 15 set, all channels set, no channel set and sparse interleaved patterns. They run under constant, alternating and pseudo-random backpressure.

// File: rtl/sadc_pkg.sv
// Shared types and fixed field widths for the sparse ADC packer.
// Assumes the output word is 16 bits with a 4-bit channel index field.
package sadc_pkg;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;
    localparam int VAL_W  = WORD_W - IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_PAT,
        ST_DATA,
        ST_END
    } fmt_state_e;
endpackage

// File: rtl/sadc_capture.sv
// Snapshot register: holds the mask and values of one capture for the
// duration of a packet. Assumes load is only raised while idle.
module sadc_capture
    import sadc_pkg::*;
#(
    parameter int CHANNELS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [CHANNELS-1:0]       cap_mask,
    input  logic [CHANNELS*VAL_W-1:0] cap_vals,
    output logic [CHANNELS-1:0]       mask_q,
    output logic [CHANNELS*VAL_W-1:0] vals_q
);
    // Store the snapshot when the sequencer accepts a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            vals_q <= '0;
        end else if (load) begin
            mask_q <= cap_mask;
            vals_q <= cap_vals;
        end
    end
endmodule

// File: rtl/sadc_lowest.sv
// Lowest-set-bit finder: gives the index of the lowest pending channel.
// Assumes the caller only uses the index when pend is non-zero.
module sadc_lowest
    import sadc_pkg::*;
#(
    parameter int CHANNELS = 16
) (
    input  logic [CHANNELS-1:0] pend,
    output logic [IDX_W-1:0]    idx
);
    logic [CHANNELS-1:0] onehot;
    logic [IDX_W-1:0]    contrib [CHANNELS];

    // Isolate the lowest set bit.
    assign onehot = pend & (~pend + CHANNELS'(1));

    genvar g;
    generate
        for (g = 0; g < CHANNELS; g++) begin : g_enc
            assign contrib[g] = onehot[g] ? IDX_W'(g) : '0;
        end
    endgenerate

    // OR the per-bit contributions into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < CHANNELS; i++) idx = idx | contrib[i];
    end
endmodule

// File: rtl/sadc_seq.sv
// Packet sequencer: walks tag, pattern, data words and end marker, and
// keeps the set of channels still to be sent. Assumes out_ready follows
// a valid/ready handshake; a word moves when out_valid && out_ready.
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int          CHANNELS = 16,
    parameter logic [15:0] TAG      = 16'h7164
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_valid,
    input  logic [CHANNELS-1:0]       cap_mask,
    input  logic                      out_ready,
    input  logic [CHANNELS-1:0]       mask_q,
    input  logic [CHANNELS*VAL_W-1:0] vals_q,
    input  logic [IDX_W-1:0]          pick_idx,
    output logic [CHANNELS-1:0]       pending,
    output logic                      load,
    output logic                      cap_ready,
    output logic                      out_valid,
    output logic [WORD_W-1:0]         out_word,
    output fmt_state_e                st
);
    localparam logic [WORD_W-1:0] END_TAG = {4'hF, TAG[11:0]};

    logic [CHANNELS-1:0] pend_next;

    // Handshake flags, remaining-channel set and word selection.
    always_comb begin
        pend_next = pending & ~(CHANNELS'(1) << pick_idx);
        cap_ready = (st == ST_IDLE);
        out_valid = (st != ST_IDLE);
        load      = cap_valid && cap_ready;
        case (st)
            ST_TAG:  out_word = TAG;
            ST_PAT:  out_word = WORD_W'(mask_q);
            ST_DATA: out_word = {pick_idx, vals_q[pick_idx*VAL_W +: VAL_W]};
            ST_END:  out_word = END_TAG;
            default: out_word = '0;
        endcase
    end

    // Advance through the packet frame on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pending <= '0;
        end else begin
            case (st)
                ST_IDLE: if (load) begin
                    st      <= ST_TAG;
                    pending <= cap_mask;
                end
                ST_TAG: if (out_ready) st <= ST_PAT;
                ST_PAT: if (out_ready) st <= (pending != '0) ? ST_DATA : ST_END;
                ST_DATA: if (out_ready) begin
                    pending <= pend_next;
                    st      <= (pend_next == '0) ? ST_END : ST_DATA;
                end
                ST_END: if (out_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sparse_adc_packer.sv
// Top of the sparse ADC packer: captures one multi-channel snapshot and
// streams a tagged, zero-suppressed packet. Assumes CHANNELS <= 16 so
// the channel index fits the 4-bit field of a data word.
module sparse_adc_packer
    import sadc_pkg::*;
#(
    parameter int          CHANNELS = 16,
    parameter logic [15:0] TAG      = 16'h7164
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_valid,
    output logic                      cap_ready,
    input  logic [CHANNELS-1:0]       cap_mask,
    input  logic [CHANNELS*VAL_W-1:0] cap_vals,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [WORD_W-1:0]         out_word
);
    logic                      load;
    logic [CHANNELS-1:0]       mask_q;
    logic [CHANNELS*VAL_W-1:0] vals_q;
    logic [CHANNELS-1:0]       pending;
    logic [IDX_W-1:0]          pick_idx;
    fmt_state_e                st;

    sadc_capture #(.CHANNELS(CHANNELS)) u_cap (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cap_mask(cap_mask), .cap_vals(cap_vals),
        .mask_q(mask_q), .vals_q(vals_q)
    );

    sadc_lowest #(.CHANNELS(CHANNELS)) u_pick (
        .pend(pending), .idx(pick_idx)
    );

    sadc_seq #(.CHANNELS(CHANNELS), .TAG(TAG)) u_seq (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_mask(cap_mask),
        .out_ready(out_ready), .mask_q(mask_q), .vals_q(vals_q),
        .pick_idx(pick_idx), .pending(pending), .load(load),
        .cap_ready(cap_ready), .out_valid(out_valid), .out_word(out_word),
        .st(st)
    );
endmodule

// File: rtl/sadc_checker.sv
// Protocol and framing checks for the sparse ADC packer, bound to the top.
module sadc_checker
    import sadc_pkg::*;
#(
    parameter int          CHANNELS = 16,
    parameter logic [15:0] TAG      = 16'h7164
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cap_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [WORD_W-1:0]   out_word,
    input logic [CHANNELS-1:0] mask_q,
    input fmt_state_e          st
);
    logic [15:0] mask16;
    assign mask16 = 16'(mask_q);

    p_first_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_word == TAG);

    p_data_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> mask16[out_word[15:12]]);

    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && out_ready) |=>
        (st != ST_DATA || out_word[15:12] > $past(out_word[15:12])));

    p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_END && out_ready) |=> (cap_ready && !out_valid));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cap_ready);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
endmodule

bind sparse_adc_packer sadc_checker #(.CHANNELS(CHANNELS), .TAG(TAG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_ready(cap_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .mask_q(mask_q), .st(st)
);

// File: tb/sparse_adc_packer_bench.sv
// Directed bench: one task per scenario, each checking its own packet.
module sparse_adc_packer_bench;
    localparam int          CH  = 16;
    localparam logic [15:0] TG  = 16'h7166;
    localparam logic [15:0] ETG = 16'hF166;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cap_valid = 1'b0;
    logic            cap_ready;
    logic [CH-1:0]   cap_mask = '0;
    logic [CH*12-1:0] cap_vals = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [15:0]     out_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sparse_adc_packer #(.CHANNELS(CH), .TAG(TG)) u_sparse_adc_packer (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_ready(cap_ready),
        .cap_mask(cap_mask), .cap_vals(cap_vals), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [CH*12-1:0] make_vals(int seed);
        logic [CH*12-1:0] v;
        for (int c = 0; c < CH; c++) v[c*12 +: 12] = 12'((seed * 37 + c * 291 + 5) & 12'hFFF);
        return v;
    endfunction

    // Offer a capture and return one cycle after it is taken.
    task automatic offer(logic [CH-1:0] m, logic [CH*12-1:0] d);
        @(negedge clk);
        cap_valid = 1'b1; cap_mask = m; cap_vals = d;
        while (!cap_ready) @(negedge clk);
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    // Send one snapshot, drain the packet under a ready pattern, compare.
    // rmode: 0 always ready, 1 alternating, 2 pseudo-random.
    task automatic run_packet(string name, logic [CH-1:0] m, logic [CH*12-1:0] d,
                              int rmode, bit intrude);
        logic [15:0] exp_q[$];
        logic [15:0] stall_word = '0;
        bit          stalled = 1'b0;
        logic [7:0]  lfsr = 8'hA5;
        int          got = 0;
        int          cyc = 0;
        bit          rdy;
        exp_q.push_back(TG);
        exp_q.push_back(m);
        for (int c = 0; c < CH; c++)
            if (m[c]) exp_q.push_back({4'(c), d[c*12 +: 12]});
        exp_q.push_back(ETG);
        offer(m, d);
        while (got < exp_q.size() && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (intrude) begin
                // R8: a competing capture while busy must not be taken.
                cap_valid = (got < exp_q.size() - 1);
                cap_mask  = ~m;
                cap_vals  = ~d;
                if (out_valid) check({name, " R8 cap_ready busy"}, 16'(cap_ready), 16'd0);
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : lfsr[0];
            out_ready = rdy;
            if (stalled) begin
                check({name, " R9 valid held"}, 16'(out_valid), 16'd1);
                check({name, " R9 word held"}, out_word, stall_word);
            end
            if (out_valid) begin
                if (rdy) begin
                    if (got == 0) check({name, " R1 tag"}, out_word, exp_q[got]);
                    else if (got == 1) check({name, " R2 R7 pattern"}, out_word, exp_q[got]);
                    else if (got == exp_q.size() - 1) check({name, " R6 end marker"}, out_word, exp_q[got]);
                    else check({name, " R3 R4 R5 data word"}, out_word, exp_q[got]);
                    got++;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    stall_word = out_word;
                end
            end else begin
                stalled = 1'b0;
            end
        end
        check({name, " R3 packet length"}, 16'(got), 16'(exp_q.size()));
        cap_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        check({name, " R6 idle after end"}, {15'd0, out_valid}, 16'd0);
        check({name, " R6 ready after end"}, {15'd0, cap_ready}, 16'd1);
    endtask

    task automatic t_reset();
        check("R10 out_valid after reset", {15'd0, out_valid}, 16'd0);
        check("R10 cap_ready after reset", {15'd0, cap_ready}, 16'd1);
    endtask

    task automatic t_edges();
        run_packet("only ch0", 16'h0001, make_vals(1), 0, 1'b0);
        run_packet("only ch15", 16'h8000, make_vals(2), 0, 1'b0);
        // Channel 15 value equal to the low bits of the end marker.
        run_packet("ch15 looks like end", 16'h8000, {12'h166, make_vals(3)[CH*12-13:0]}, 1, 1'b0);
    endtask

    task automatic t_full_and_empty();
        run_packet("all channels", 16'hFFFF, make_vals(4), 2, 1'b0);
        run_packet("R7 empty mask", 16'h0000, make_vals(5), 1, 1'b0);
    endtask

    task automatic t_sparse();
        run_packet("alternating", 16'h5A5A, make_vals(6), 2, 1'b0);
        run_packet("sparse high", 16'hC003, make_vals(7), 1, 1'b0);
    endtask

    task automatic t_intrude();
        run_packet("R8 busy capture", 16'h0F10, make_vals(8), 2, 1'b1);
        run_packet("R8 after intrude", 16'h2222, make_vals(9), 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edges();
        t_full_and_empty();
        t_sparse();
        t_intrude();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule